// File: doc/BRIEF.md
# Write-Only Serial Volume Command Receiver

This block is a two-wire serial bus target that accepts write transactions only. It runs on a fast system clock and oversamples the clock line and the data line of the bus. A transaction opens with a START condition. The first byte is compared with a fixed device address (0x88, write direction included). When the address matches, the block acknowledges it and every data byte after it, and hands each data byte to the volume logic as a one-cycle strobe. This goes on until a STOP. When the address does not match, the block stays silent and waits for the next START.

After reset the block ignores the bus for a programmable number of clock cycles so that the supply can settle. It drives the data line only through an active-high pull-down enable, so the pad stays open-drain.

The controller has seven states, each with named transitions:
- `ST_SETTLE` moves to `ST_IDLE` when the settle timer expires.
- From any other state, a START goes to `ST_ADDR` and a STOP goes to `ST_IDLE`.
- `ST_ADDR` goes, on the falling clock edge after its eighth bit, to `ST_ADDR_ACK` when the address matches and to `ST_IGNORE` when it does not.
- `ST_ADDR_ACK` goes to `ST_DATA` on the next falling clock edge.
- `ST_DATA` goes to `ST_DATA_ACK` on the falling edge after its eighth bit, and pulses the byte strobe at that moment.
- `ST_DATA_ACK` goes back to `ST_DATA` on the next falling edge.

Top module: `vol_i2c_rx`

## Requirements
- R1: After reset, `sda_oe` and `rx_valid` are low.
- R2: For the first `SETTLE_CYCLES` clock cycles after reset, no bus activity causes an acknowledge or a byte strobe, even a complete valid write.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, bits clocked without a new START are neither acknowledged nor delivered.
- R4: SDA is sampled on each rising SCL edge, most significant bit first. A byte is complete after eight rising edges.
- R5: An address byte equal to 0x88 (bits 7..0 = 1000_1000, bit 0 is the write direction and is 0) is acknowledged. `sda_oe` is high from shortly after the eighth SCL falling edge until shortly after the ninth SCL falling edge, which covers the whole high phase of the ninth clock.
- R6: Any other address byte, including 0x89 (read direction), gets no acknowledge. The bus is then ignored, with no acknowledge and no strobe, until the next START.
- R7: Each data byte that follows a matching address is acknowledged like the address. It produces a `rx_valid` pulse exactly one clock long, with the byte on `rx_data`. There is no limit on the number of bytes per transaction.
- R8: A repeated START at any point, including in the middle of a byte, discards the partial byte and treats the next byte as a new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (includes this block's own pull-down) |
| sda_oe | output | 1 | 1 = pull the data line low (acknowledge), 0 = release |
| rx_valid | output | 1 | One-cycle strobe for an accepted data byte |
| rx_data | output | 8 | Accepted data byte, valid while `rx_valid` is high |

## Verification
Several transaction shapes are driven:
- A complete, correct write issued while the settle window is still open, which separates a working settle timer from one that lets the bus through early.
- Correct writes with one data byte and with two dozen data bytes, which separate a byte-count limit from an unbounded run.
- Address 0x90 and address 0x89 followed by data, which separate a full address compare from one that skips the direction bit.
- A repeated START in the middle of a data byte, and bits clocked after a STOP, which show whether the bit counter and the address phase really restart.

A behavioural model checks the acknowledge enable, the strobe and the data on every clock. The master also samples the shared line during each ninth clock.

// File: rtl/vol_rx_pkg.sv
package vol_rx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_e;
endpackage

// File: rtl/bus_sync.sv
// Two-flop synchronizer per line plus one history stage for edge detection.
module bus_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic meta;
            logic stab;
            logic hist;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta <= 1'b1;
                    stab <= 1'b1;
                    hist <= 1'b1;
                end else begin
                    meta <= din[i];
                    stab <= meta;
                    hist <= stab;
                end
            end
            assign cur[i]  = stab;
            assign prev[i] = hist;
        end
    endgenerate
endmodule

// File: rtl/settle_timer.sv
// Counts clock cycles after reset; done stays high once the count is reached.
module settle_timer #(
    parameter int CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(CYCLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/byte_shift.sv
// MSB-first shift register with a bit counter.
module byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int NW = $clog2(W + 1);

    logic [NW-1:0] nbits;

    assign full = (nbits == NW'(W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            nbits <= '0;
        end else if (clr) begin
            nbits <= '0;
        end else if (en) begin
            data  <= {data[W-2:0], bit_in};
            nbits <= nbits + 1'b1;
        end
    end
endmodule

// File: rtl/vol_i2c_rx.sv
module vol_i2c_rx
    import vol_rx_pkg::*;
#(
    parameter int          SETTLE_CYCLES = 10_000_000,
    parameter logic [7:0]  DEV_ADDR      = 8'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data
);
    logic [1:0] line_cur;
    logic [1:0] line_prev;
    logic       settled;

    bus_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .cur  (line_cur),
        .prev (line_prev)
    );

    settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .done (settled)
    );

    logic scl_cur, scl_prev, sda_cur, sda_prev;
    assign scl_cur  = line_cur[1];
    assign sda_cur  = line_cur[0];
    assign scl_prev = line_prev[1];
    assign sda_prev = line_prev[0];

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_cur & ~scl_prev;
    assign scl_fall  = ~scl_cur & scl_prev;
    assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;

    logic              sh_clr, sh_en, sh_full;
    logic [BYTE_W-1:0] sh_data;

    byte_shift #(.W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sh_clr),
        .en    (sh_en),
        .bit_in(sda_cur),
        .data  (sh_data),
        .full  (sh_full)
    );

    rx_state_e state_q, state_d;
    logic      accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SETTLE;
        else
            state_q <= state_d;
    end

    // Next state and shifter control
    always_comb begin
        state_d = state_q;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        accept  = 1'b0;
        if (state_q != ST_SETTLE && start_det) begin
            state_d = ST_ADDR;
            sh_clr  = 1'b1;
        end else if (state_q != ST_SETTLE && stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_SETTLE: begin
                    if (settled)
                        state_d = ST_IDLE;
                end
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && !sh_full) begin
                        sh_en = 1'b1;
                    end else if (scl_fall && sh_full) begin
                        if (state_q == ST_ADDR) begin
                            state_d = (sh_data == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                        end else begin
                            state_d = ST_DATA_ACK;
                            accept  = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_DATA;
                        sh_clr  = 1'b1;
                    end
                end
                ST_IDLE, ST_IGNORE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            sda_oe   <= (state_d == ST_ADDR_ACK) || (state_d == ST_DATA_ACK);
            rx_valid <= accept;
            if (accept)
                rx_data <= sh_data;
        end
    end
endmodule

// File: rtl/vol_i2c_rx_chk.sv
module vol_i2c_rx_chk
    import vol_rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      settled,
    input logic      scl_s,
    input logic      start_det,
    input logic      sda_oe,
    input logic      rx_valid,
    input rx_state_e state
);
    AST_QUIET_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |-> (!sda_oe && !rx_valid)); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_ACK_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R5

    AST_ACK_ENDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s); // R5

    AST_SILENT_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe); // R6

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && settled) |=> (!sda_oe && state == ST_ADDR)); // R8
endmodule

bind vol_i2c_rx vol_i2c_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .settled  (settled),
    .scl_s    (scl_cur),
    .start_det(start_det),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .state    (state_q)
);

// File: tb/vol_i2c_rx_test.sv
`timescale 1ns/1ps
module vol_i2c_rx_test;
    localparam int SETTLE = 2000;
    localparam int Q      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, rx_valid;
    logic [7:0] rx_data;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    vol_i2c_rx #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // Behavioural reference model
    logic [1:0] dq[$];
    int  m_cyc, m_st, m_bits, m_sh;
    bit  exp_oe, exp_valid;
    int  exp_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq = '{2'b11, 2'b11, 2'b11};
            m_cyc = 0; m_st = 0; m_bits = 0; m_sh = 0;
            exp_oe = 0; exp_valid = 0; exp_data = 0;
        end else begin
            logic [1:0] c, p;
            int  nst;
            bit  acc;
            dq.push_back({scl_m, sda_line});
            c = dq[1];
            p = dq[0];
            void'(dq.pop_front());
            m_cyc++;
            nst = m_st;
            acc = 0;
            if (m_st == 0) begin
                if (m_cyc > SETTLE) nst = 1;
            end else if (c[1] && p[1] && p[0] && !c[0]) begin
                nst = 2; m_bits = 0;
            end else if (c[1] && p[1] && !p[0] && c[0]) begin
                nst = 1;
            end else begin
                if (m_st == 2 || m_st == 4) begin
                    if (c[1] && !p[1] && m_bits < 8) begin
                        m_sh = ((m_sh << 1) | int'(c[0])) & 255;
                        m_bits++;
                    end else if (!c[1] && p[1] && m_bits == 8) begin
                        if (m_st == 2) nst = (m_sh == 'h88) ? 3 : 6;
                        else begin nst = 5; acc = 1; end
                    end
                end else if (m_st == 3 || m_st == 5) begin
                    if (!c[1] && p[1]) begin nst = 4; m_bits = 0; end
                end
            end
            exp_oe    = (nst == 3 || nst == 5);
            exp_valid = acc;
            if (acc) exp_data = m_sh;
            m_st = nst;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            compared++;
            if (sda_oe !== exp_oe || rx_valid !== exp_valid ||
                (exp_valid && rx_data !== 8'(exp_data))) begin
                mismatched++;
                $display("FAIL %s: oe/valid/data got %0b/%0b/%02h exp %0b/%0b/%02h",
                         cur_req, sda_oe, rx_valid, rx_data, exp_oe, exp_valid, 8'(exp_data));
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0b exp %0b", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  wait_q(Q);
        scl_m = 1'b1; wait_q(2 * Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic want_ack, input string req);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        check(req, ~sda_line, want_ack);
        wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    initial begin
        wait_q(5);
        check("R1", sda_oe, 1'b0);
        check("R1", rx_valid, 1'b0);
        rst_n = 1'b1;
        wait_q(3);
        check("R1", sda_oe, 1'b0);

        // R2: complete write during settle window
        cur_req = "R2";
        do_start();
        send_byte(8'h88, 1'b0, "R2 addr during settle");
        send_byte(8'h3C, 1'b0, "R2 data during settle");
        do_stop();
        wait_q(SETTLE + 50);

        // R5 R7 R4: normal write, two bytes
        cur_req = "R7";
        do_start();
        send_byte(8'h88, 1'b1, "R5 addr ack");
        send_byte(8'h5A, 1'b1, "R7 data ack");
        send_byte(8'hC3, 1'b1, "R4 data ack");
        do_stop();

        // R6: wrong address, then read-direction address
        cur_req = "R6";
        do_start();
        send_byte(8'h90, 1'b0, "R6 addr 0x90");
        send_byte(8'h77, 1'b0, "R6 data after miss");
        do_stop();
        do_start();
        send_byte(8'h89, 1'b0, "R6 addr 0x89");
        send_byte(8'h01, 1'b0, "R6 data after 0x89");
        // R6: miss followed by repeated start with matching address
        do_start();
        send_byte(8'h88, 1'b1, "R6 recovery addr");
        send_byte(8'hA5, 1'b1, "R6 recovery data");
        do_stop();

        // R8: repeated start in the middle of a data byte
        cur_req = "R8";
        do_start();
        send_byte(8'h88, 1'b1, "R8 first addr");
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_start();
        send_byte(8'h88, 1'b1, "R8 new addr");
        send_byte(8'h11, 1'b1, "R8 data");
        do_stop();

        // R3: bits clocked after STOP with no START
        cur_req = "R3";
        send_byte(8'h88, 1'b0, "R3 no start addr");
        send_byte(8'h42, 1'b0, "R3 no start data");

        // R7: long run of data bytes in one transaction
        cur_req = "R7";
        do_start();
        send_byte(8'h88, 1'b1, "R7 long addr");
        for (int k = 0; k < 24; k++)
            send_byte(8'((k * 37 + 5) & 8'hFF), 1'b1, "R7 long data");
        do_stop();
        wait_q(20);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule